// File: doc/BRIEF.md
# Eight-bit up/down timer with buffered compare

This block is an 8-bit timer/counter with one compare channel. Each time a count enable arrives, the counter steps up or down. The enable can come from three places: an internal prescaled tick input, or either edge of an asynchronous external pin. A clock-select field of zero stops the counter. The end of the count sequence (TOP) is either the fixed value 0xFF or the active compare value.

Software writes the compare value into a buffer. The buffer moves into the active compare register at the end of a period, so that a mid-period write cannot cut a period short. When the counter matches the active compare value on a counting step, a sticky flag is set and a waveform pin toggles. If the flag's enable bit is set, an interrupt request is raised.

The block carries no data stream, so it has no valid/ready interface. All pins are plain control and status signals, and the register writes are single-cycle strobes with no back-pressure.

Top module: `bidir_timer8`

## Requirements
- R1: After reset the counter, the active compare value, the compare flag, the interrupt and the waveform output are all 0.
- R2: With `clk_sel` = 000 the counter holds its value. With `clk_sel` from 001 to 101 the counter makes one step in each cycle where `int_tick` is 1.
- R3: With `clk_sel` = 111 the counter steps once for each rising edge of `ext_pin`. With `clk_sel` = 110 it steps once for each falling edge. Both edges pass through a two-flop synchronizer, so a pin change set up before clock edge E0 moves the counter at edge E0+2.
- R4: When `count_down` = 0 the counter increments. When it is at TOP, the step makes it 0x00. TOP is 0xFF when `top_is_cmp` = 0, and it is the active compare value when `top_is_cmp` = 1.
- R5: When `count_down` = 1 the counter decrements. When it is at 0x00, the step loads TOP.
- R6: While the counter runs, a compare write (`cmp_we`) goes to the buffer only. The buffer is copied to the active value (`cmp_value`) on a counting step taken while the counter equals TOP. While `clk_sel` = 000, a compare write reaches `cmp_value` in the next cycle.
- R7: A counting step taken while the counter equals `cmp_value` sets `cmp_flag` and toggles `wave`. Both changes are visible in the next cycle.
- R8: `flag_clr` = 1 clears `cmp_flag` in the next cycle. A match in the same cycle wins, and the flag stays set.
- R9: `irq` is 1 exactly when `cmp_flag` and `irq_en` are both 1.
- R10: `cnt_we` loads `cnt_wdata` into the counter in the next cycle and overrides a step in the same cycle. The first counting step after that write cannot produce a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Count source: 000 off, 001-101 internal tick, 110 pin falling, 111 pin rising |
| int_tick | input | 1 | Internal prescaled count enable |
| ext_pin | input | 1 | Asynchronous external count pin |
| count_down | input | 1 | 1 = decrement, 0 = increment |
| top_is_cmp | input | 1 | 1 = TOP is the active compare value, 0 = TOP is 0xFF |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_we | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | 8 | Compare write value |
| flag_clr | input | 1 | Write-one-to-clear for the compare flag |
| irq_en | input | 1 | Interrupt enable for the compare flag |
| count | output | 8 | Counter value |
| cmp_value | output | 8 | Active compare value |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| wave | output | 1 | Toggles on each compare match |

## Verification
A wrong counter or a wrong TOP choice shows on `count` one cycle after the faulty step. A wrong active compare value shows on `cmp_value` as soon as the buffer is copied, and it shows again in the timing of later matches. A lost or extra match shows on `cmp_flag`, `wave` and `irq` one cycle after the step. A synchronizer with the wrong depth or a wrong edge polarity moves the first external step away from edge E0+2. The bench runs a cycle model and compares every output in every cycle, so each of these faults is reported within one cycle of the point where it becomes visible.

// File: rtl/t8_pkg.sv
package t8_pkg;
  localparam logic [2:0] CS_OFF  = 3'b000;
  localparam logic [2:0] CS_FALL = 3'b110;
  localparam logic [2:0] CS_RISE = 3'b111;

  typedef enum logic [1:0] {SRC_NONE, SRC_INT, SRC_FALL, SRC_RISE} src_e;

  function automatic src_e decode_src(input logic [2:0] sel);
    case (sel)
      CS_OFF:  decode_src = SRC_NONE;
      CS_FALL: decode_src = SRC_FALL;
      CS_RISE: decode_src = SRC_RISE;
      default: decode_src = SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/t8_clksel.sv
module t8_clksel
  import t8_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       int_tick,
  input  logic       ext_pin,
  output logic       tick
);
  // sh[SYNC-1] is the synchronized pin, sh[SYNC] is its previous value
  logic [SYNC:0] sh;
  src_e src;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ext_pin};
  end

  assign src  = decode_src(sel);
  assign rise = sh[SYNC-1] & ~sh[SYNC];
  assign fall = ~sh[SYNC-1] & sh[SYNC];

  always_comb begin
    case (src)
      SRC_INT:  tick = int_tick;
      SRC_FALL: tick = fall;
      SRC_RISE: tick = rise;
      default:  tick = 1'b0;
    endcase
  end

  // R3: each detected pin edge yields a single count enable
  p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (src == SRC_RISE || src == SRC_FALL)) ##1 (sel == $past(sel)) |-> !tick);
endmodule

// File: rtl/t8_counter.sv
module t8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         down,
  input  logic [W-1:0] top,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         blk
);
  localparam logic [W-1:0] BOTTOM = '0;

  logic [W-1:0] nxt;

  assign at_top = (cnt == top);

  always_comb begin
    if (down) nxt = (cnt == BOTTOM) ? top : cnt - 1'b1;
    else      nxt = at_top ? BOTTOM : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= BOTTOM;
      blk <= 1'b0;
    end else begin
      if (wr)        cnt <= wdata;
      else if (tick) cnt <= nxt;
      if (wr)        blk <= 1'b1;
      else if (tick) blk <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && !down && at_top) |=> (cnt == BOTTOM));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && down && cnt == BOTTOM) |=> (cnt == $past(top)));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata) && blk));
endmodule

// File: rtl/t8_compare.sv
module t8_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         stopped,
  input  logic [W-1:0] cnt,
  input  logic         at_top,
  input  logic         blk,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] act,
  output logic         flag,
  output logic         wave
);
  logic [W-1:0] shadow;
  logic         match;

  assign match = tick && (cnt == act) && !blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
      flag   <= 1'b0;
      wave   <= 1'b0;
    end else begin
      if (wr) shadow <= wdata;
      if (wr && stopped)       act <= wdata;
      else if (tick && at_top) act <= shadow;
      if (match)    flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (match) wave <= ~wave;
    end
  end

  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr && stopped)) |=> $stable(act));
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (flag && wave != $past(wave)));
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !flag);
  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !flag) |=> !flag);
endmodule

// File: rtl/bidir_timer8.sv
module bidir_timer8
  import t8_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   clk_sel,
  input  logic         int_tick,
  input  logic         ext_pin,
  input  logic         count_down,
  input  logic         top_is_cmp,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         flag_clr,
  input  logic         irq_en,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_value,
  output logic         cmp_flag,
  output logic         irq,
  output logic         wave
);
  localparam logic [W-1:0] MAXV = '1;

  logic         tick, at_top, blk, stopped;
  logic [W-1:0] top;

  assign stopped = (clk_sel == CS_OFF);
  assign top     = top_is_cmp ? cmp_value : MAXV;

  t8_clksel #(.SYNC(SYNC)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .int_tick(int_tick),
    .ext_pin(ext_pin), .tick(tick)
  );

  t8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .down(count_down), .top(top),
    .wr(cnt_we), .wdata(cnt_wdata), .cnt(count), .at_top(at_top), .blk(blk)
  );

  t8_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stopped(stopped), .cnt(count),
    .at_top(at_top), .blk(blk), .wr(cmp_we), .wdata(cmp_wdata), .clr(flag_clr),
    .act(cmp_value), .flag(cmp_flag), .wave(wave)
  );

  assign irq = cmp_flag & irq_en;

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cnt_we) |=> $stable(count));
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmp_flag && irq_en));
endmodule

// File: tb/tb_bidir_timer8.sv
module tb_bidir_timer8;
  logic       clk = 0, rst_n = 0;
  logic [2:0] clk_sel = 0;
  logic       int_tick = 0, ext_pin = 0, count_down = 0, top_is_cmp = 0;
  logic       cnt_we = 0, cmp_we = 0, flag_clr = 0, irq_en = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [7:0] count, cmp_value;
  logic       cmp_flag, irq, wave;

  int total = 0, bad = 0;
  bit done = 0;

  // bench cycle model, built from the requirements
  logic [7:0] m_cnt = 0, m_buf = 0, m_act = 0;
  logic       m_flag = 0, m_wave = 0, m_blk = 0;
  logic [2:0] m_sh = 0;

  always #4 clk = ~clk;

  bidir_timer8 dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .int_tick(int_tick),
    .ext_pin(ext_pin), .count_down(count_down), .top_is_cmp(top_is_cmp),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .irq_en(irq_en), .count(count), .cmp_value(cmp_value),
    .cmp_flag(cmp_flag), .irq(irq), .wave(wave)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tick();
    case (clk_sel)
      3'b000:  return 1'b0;
      3'b110:  return ~m_sh[1] & m_sh[2];
      3'b111:  return m_sh[1] & ~m_sh[2];
      default: return int_tick;
    endcase
  endfunction

  function automatic logic [7:0] exp_top();
    return top_is_cmp ? m_act : 8'hFF;
  endfunction

  task automatic step();
    logic tk, mt;
    logic [7:0] tp, n_cnt, n_act;
    tk = exp_tick();
    tp = exp_top();
    mt = tk && (m_cnt == m_act) && !m_blk;
    n_cnt = m_cnt;
    if (cnt_we) n_cnt = cnt_wdata;
    else if (tk) begin
      if (count_down) n_cnt = (m_cnt == 8'h00) ? tp : m_cnt - 8'd1;
      else            n_cnt = (m_cnt == tp) ? 8'h00 : m_cnt + 8'd1;
    end
    n_act = m_act;
    if (cmp_we && clk_sel == 3'b000) n_act = cmp_wdata;
    else if (tk && m_cnt == tp)      n_act = m_buf;
    @(posedge clk);
    m_sh  = {m_sh[1:0], ext_pin};
    if (cmp_we) m_buf = cmp_wdata;
    m_act = n_act;
    m_cnt = n_cnt;
    if (cnt_we) m_blk = 1'b1; else if (tk) m_blk = 1'b0;
    if (mt) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
    if (mt) m_wave = ~m_wave;
    @(negedge clk);
    chk(count_down ? "R5 count" : "R4 count", count, m_cnt);
    chk("R6 cmp_value", cmp_value, m_act);
    chk("R7 flag", cmp_flag, m_flag);
    chk("R7 wave", wave, m_wave);
    chk("R9 irq", irq, m_flag & irq_en);
  endtask

  task automatic idle_strobes();
    cnt_we = 0; cmp_we = 0; flag_clr = 0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1; cnt_wdata = v; step(); cnt_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 count", count, 0); chk("R1 cmp", cmp_value, 0);
    chk("R1 flag", cmp_flag, 0); chk("R1 irq", irq, 0); chk("R1 wave", wave, 0);

    // R2 stopped holds, internal tick counts
    clk_sel = 3'b000; int_tick = 1;
    repeat (5) step();
    chk("R2 stopped", count, 0);
    clk_sel = 3'b010;
    repeat (3) step();
    chk("R2 internal", count, 3);

    // R4 wrap at 0xFF
    clk_sel = 3'b000; wr_cnt(8'hFE);
    chk("R10 load", count, 8'hFE);
    clk_sel = 3'b001; step(); step();
    chk("R4 wrap", count, 8'h00);
    flag_clr = 1; int_tick = 0; step(); flag_clr = 0;
    chk("R8 clear", cmp_flag, 0);

    // R6 write while stopped goes straight to active
    clk_sel = 3'b000; cmp_we = 1; cmp_wdata = 8'h10; step(); cmp_we = 0;
    chk("R6 stopped write", cmp_value, 8'h10);

    // R10 write blocks the next match
    wr_cnt(8'h10);
    clk_sel = 3'b001; int_tick = 1; step();
    chk("R10 blocked", cmp_flag, 0);
    chk("R10 counted", count, 8'h11);

    // R7 / R9 match, R8 clear
    irq_en = 1; int_tick = 0; wr_cnt(8'h0F);
    int_tick = 1; step(); step();
    chk("R7 flag set", cmp_flag, 1);
    chk("R9 irq", irq, 1);
    int_tick = 0; flag_clr = 1; step(); flag_clr = 0;
    chk("R8 cleared", cmp_flag, 0);

    // R6 buffered write while running, copy at TOP
    top_is_cmp = 1; wr_cnt(8'h0E);
    cmp_we = 1; cmp_wdata = 8'h20; step(); cmp_we = 0;
    chk("R6 buffered", cmp_value, 8'h10);
    int_tick = 1; step(); step(); step();
    chk("R4 top wrap", count, 8'h00);
    chk("R6 copied", cmp_value, 8'h20);

    // R5 down reload to TOP
    int_tick = 0; count_down = 1; wr_cnt(8'h01);
    int_tick = 1; step(); step();
    chk("R5 reload", count, 8'h20);

    // R3 external edges
    int_tick = 0; count_down = 0; top_is_cmp = 0; clk_sel = 3'b111;
    wr_cnt(8'h05);
    ext_pin = 1; step(); step();
    chk("R3 latency", count, 8'h05);
    step();
    chk("R3 rise", count, 8'h06);
    ext_pin = 0; repeat (4) step();
    chk("R3 no fall on rise", count, 8'h06);
    clk_sel = 3'b110; ext_pin = 1; repeat (4) step();
    ext_pin = 0; repeat (3) step();
    chk("R3 fall", count, 8'h07);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 24 == 0) clk_sel = 3'($urandom);
      if ($urandom % 40 == 0) count_down = ~count_down;
      if ($urandom % 40 == 0) top_is_cmp = ~top_is_cmp;
      if ($urandom % 30 == 0) irq_en = ~irq_en;
      if ($urandom % 4 == 0)  ext_pin = ~ext_pin;
      int_tick  = ($urandom % 3) != 0;
      cnt_we    = ($urandom % 40) == 0;
      cnt_wdata = 8'($urandom);
      cmp_we    = ($urandom % 25) == 0;
      cmp_wdata = 8'($urandom % 64);
      flag_clr  = ($urandom % 8) == 0;
      step();
      idle_strobes();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule